// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register file of one 16-pin general-purpose I/O port. A simple synchronous register bus (word address, write enable, four byte strobes, 32-bit write data, combinational read data) reaches configuration fields for each pin: direction mode, drive type, slew speed, pull resistor and a 4-bit alternate-function code. It also reaches an output latch, a synchronized view of the pad levels and a write-only set/clear port. The set/clear port changes single output bits without a read-modify-write.

From these fields the block drives the per-pin output enable, output value and pull requests toward pad logic. A pin in push-pull output mode always drives its latch value. A pin in open-drain output mode pulls low only while its latch bit is 0, and otherwise releases the pad. A per-pin lock input from an external sequencer freezes that pin's configuration fields. The output latch stays writable while a pin is locked.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every readable register reads 0 and all of pad_oe, pad_out, pad_pu and pad_pd are 0.
- R2: The word address selects the register: 0 mode, 1 drive type, 2 speed, 3 pull, 4 pad input, 5 output latch, 6 set/clear, 7 alternate function for pins 0–7, 8 alternate function for pins 8–15. Any other address reads 0 and ignores writes.
- R3: Mode, speed and pull hold 2 bits per pin, with pin y at bits 2y+1:2y. A write updates only the bytes whose strobe is 1, and the register reads back what was written.
- R4: The drive-type register holds one bit per pin in bits 15:0 (0 push-pull, 1 open-drain). The output latch reads back the last value written to bits 15:0, with byte strobes honoured. Bits 31:16 of both read 0.
- R5: A write to the set/clear register sets latch bit y for a 1 in bit y and clears latch bit y for a 1 in bit y+16. A 0 leaves the bit unchanged. Only strobed bytes act, and the register reads 0.
- R6: When the same set/clear write both sets and clears a pin, the pin ends up set.
- R7: The pad input register reads the pad levels in bits 15:0 through a two-flop synchronizer. A level applied before clock edge k is readable after edge k+1 and not after edge k. Bits 31:16 read 0, and writes to the register have no effect.
- R8: Only a pin with mode 01 drives its pad. In push-pull it drives pad_oe=1 and pad_out equal to its latch bit. In open-drain it drives pad_out=0 and pad_oe equal to the inverse of its latch bit. Modes 00, 10 and 11 give pad_oe=0 and pad_out=0.
- R9: A pull code of 01 raises pad_pu and a code of 10 raises pad_pd. Codes 00 and 11 raise neither.
- R10: The alternate-function registers hold a 4-bit code per pin. Pin y (0–7) is at bits 4y+3:4y of address 7, and pin 8+y is at the same bits of address 8.
- R11: While pin_lock[y] is 1, writes leave pin y's mode, type, speed, pull and alternate-function bits unchanged. Fields of unlocked pins still update in the same write.
- R12: Lock has no effect on output latch writes or set/clear writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_lock | input | 16 | Per-pin configuration lock |
| pad_in | input | 16 | Pad levels, asynchronous |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output value |
| pad_pu | output | 16 | Per-pin pull-up request |
| pad_pd | output | 16 | Per-pin pull-down request |

## Verification
A wrong output latch or configuration bit shows on pad_oe or pad_out at the next falling edge after the write. It also shows on bus_rdata as soon as the address is presented, because the read path has no register. The bench sweeps every pin, mode, drive type and latch value, and every pin and pull code. It runs several hundred pseudo-random set/clear and latch writes with random byte strobes against an arithmetic model. Synchronizer depth errors show up as the pad input register changing one edge early or late.

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       pin_lock,
  input  logic [15:0]       pad_in,
  output logic [15:0]       pad_oe,
  output logic [15:0]       pad_out,
  output logic [15:0]       pad_pu,
  output logic [15:0]       pad_pd
);
  localparam int PINS = 16;
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TYPE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SPEED = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PULL  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_SC    = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_AFLO  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_AFHI  = ADDR_W'(8);

  logic [31:0]     cfg_mode, cfg_speed, cfg_pull, cfg_af_lo, cfg_af_hi;
  logic [PINS-1:0] cfg_type, out_q, sync1, in_q;
  logic [1:0]      sync_age;

  logic [31:0] bmask, lk2, lklo, lkhi;
  assign bmask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};

  for (genvar i = 0; i < 32; i++) begin : g_lock_spread
    assign lk2[i]  = pin_lock[i/2];
    assign lklo[i] = pin_lock[i/4];
    assign lkhi[i] = pin_lock[8 + i/4];
  end

  wire hit_mode  = bus_we && bus_addr == A_MODE;
  wire hit_type  = bus_we && bus_addr == A_TYPE;
  wire hit_speed = bus_we && bus_addr == A_SPEED;
  wire hit_pull  = bus_we && bus_addr == A_PULL;
  wire hit_out   = bus_we && bus_addr == A_OUT;
  wire hit_sc    = bus_we && bus_addr == A_SC;
  wire hit_aflo  = bus_we && bus_addr == A_AFLO;
  wire hit_afhi  = bus_we && bus_addr == A_AFHI;

  wire [31:0]     m2   = bmask & ~lk2;
  wire [PINS-1:0] m1   = bmask[15:0] & ~pin_lock;
  wire [PINS-1:0] sc_set = hit_sc ? (bus_wdata[15:0] & bmask[15:0]) : '0;
  wire [PINS-1:0] sc_clr = hit_sc ? (bus_wdata[31:16] & bmask[31:16]) : '0;

  logic [PINS-1:0] out_next;
  always_comb begin
    out_next = out_q;
    if (hit_out) out_next = (out_q & ~bmask[15:0]) | (bus_wdata[15:0] & bmask[15:0]);
    out_next = (out_next & ~sc_clr) | sc_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_mode  <= '0;
      cfg_type  <= '0;
      cfg_speed <= '0;
      cfg_pull  <= '0;
      cfg_af_lo <= '0;
      cfg_af_hi <= '0;
      out_q     <= '0;
      sync1     <= '0;
      in_q      <= '0;
      sync_age  <= '0;
    end else begin
      if (hit_mode)  cfg_mode  <= (cfg_mode  & ~m2) | (bus_wdata & m2);
      if (hit_type)  cfg_type  <= (cfg_type  & ~m1) | (bus_wdata[15:0] & m1);
      if (hit_speed) cfg_speed <= (cfg_speed & ~m2) | (bus_wdata & m2);
      if (hit_pull)  cfg_pull  <= (cfg_pull  & ~m2) | (bus_wdata & m2);
      if (hit_aflo)  cfg_af_lo <= (cfg_af_lo & ~(bmask & ~lklo)) | (bus_wdata & bmask & ~lklo);
      if (hit_afhi)  cfg_af_hi <= (cfg_af_hi & ~(bmask & ~lkhi)) | (bus_wdata & bmask & ~lkhi);
      out_q <= out_next;
      sync1 <= pad_in;
      in_q  <= sync1;
      if (sync_age != 2'd2) sync_age <= sync_age + 2'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = cfg_mode;
      A_TYPE:  bus_rdata = {16'h0, cfg_type};
      A_SPEED: bus_rdata = cfg_speed;
      A_PULL:  bus_rdata = cfg_pull;
      A_IN:    bus_rdata = {16'h0, in_q};
      A_OUT:   bus_rdata = {16'h0, out_q};
      A_AFLO:  bus_rdata = cfg_af_lo;
      A_AFHI:  bus_rdata = cfg_af_hi;
      default: bus_rdata = '0;
    endcase
  end

  for (genvar y = 0; y < PINS; y++) begin : g_pad
    wire drv = cfg_mode[2*y +: 2] == 2'b01;
    assign pad_oe[y]  = drv & (cfg_type[y] ? ~out_q[y] : 1'b1);
    assign pad_out[y] = drv & ~cfg_type[y] & out_q[y];
    assign pad_pu[y]  = cfg_pull[2*y +: 2] == 2'b01;
    assign pad_pd[y]  = cfg_pull[2*y +: 2] == 2'b10;
  end

  a_r5_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sc |=> ((out_q & $past(sc_set)) == $past(sc_set)));
  a_r6_clear_yields: assert property (@(posedge clk) disable iff (!rst_n)
    hit_sc |=> ((out_q & $past(sc_clr & ~sc_set)) == 16'h0));
  a_r7_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_age == 2'd2) |-> (in_q == $past(pad_in, 2)));
  a_r8_no_float_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == 16'h0));
  a_r9_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu & pad_pd) == 16'h0));
  a_r11_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mode |=> (((cfg_mode ^ $past(cfg_mode)) & $past(lk2)) == 32'h0));
  a_r11_type_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hit_type |=> (((cfg_type ^ $past(cfg_type)) & $past(pin_lock)) == 16'h0));
endmodule

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  bus_addr = 0;
  logic        bus_we = 0;
  logic [3:0]  bus_be = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_lock = 0;
  logic [15:0] pad_in = 0;
  logic [15:0] pad_oe, pad_out, pad_pu, pad_pd;
  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gpio_port_bank #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_lock(pin_lock), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  function automatic logic [31:0] bytes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] lockmask(input logic [3:0] a, input logic [15:0] l);
    logic [31:0] r = 0;
    for (int i = 0; i < 32; i++) begin
      case (a)
        4'd1:    r[i] = (i < 16) ? l[i] : 1'b1;
        4'd7:    r[i] = l[i/4];
        4'd8:    r[i] = l[8 + i/4];
        default: r[i] = l[i/2];
      endcase
    end
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_be = be; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a_val, b_val, exp, odr, lk;
    logic [3:0] be;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset pads", {pad_oe, pad_out}, 0);
    check("R1 reset pulls", {pad_pu, pad_pd}, 0);

    // R2/R3/R10 full writes and readback, unmapped addresses
    for (int a = 0; a < 16; a++) begin
      seed = nxt(seed);
      wr(4'(a), 4'hF, seed);
      rd(4'(a), v);
      case (a)
        0, 2, 3: check("R3 field readback", v, seed);
        7, 8:    check("R10 alt-function readback", v, seed);
        1, 5:    check("R4 upper bits zero", v, {16'h0, seed[15:0]});
        4, 6:    ;
        default: check("R2 unmapped reads zero", v, 0);
      endcase
    end

    // R3 byte strobes on config
    for (int k = 0; k < 16; k++) begin
      be = 4'(k);
      wr(4'd2, 4'hF, 32'hA5A5_5A5A);
      wr(4'd2, be, 32'h0F0F_F0F0);
      rd(4'd2, v);
      check("R3 speed byte strobe", v, (32'hA5A5_5A5A & ~bytes(be)) | (32'h0F0F_F0F0 & bytes(be)));
    end

    // R4/R5/R6 random latch and set/clear traffic
    wr(4'd5, 4'hF, 0);
    odr = 0;
    for (int k = 0; k < 400; k++) begin
      seed = nxt(seed); v = seed;
      seed = nxt(seed); be = seed[7:4];
      if (seed[0]) begin
        wr(4'd5, be, v);
        odr[15:0] = (odr[15:0] & ~bytes(be)) | (v[15:0] & bytes(be));
      end else begin
        wr(4'd6, be, v);
        odr[15:0] = (odr[15:0] & ~(v[31:16] & bytes(be)[31:16])) | (v[15:0] & bytes(be)[15:0]);
      end
      rd(4'd5, a_val);
      check(seed[0] ? "R4 latch strobed write" : "R5 set/clear", a_val, odr);
    end
    rd(4'd6, v);
    check("R5 set/clear reads zero", v, 0);
    wr(4'd5, 4'hF, 0);
    wr(4'd6, 4'hF, 32'h8001_8001);
    rd(4'd5, v);
    check("R6 set wins over clear", v, 32'h8001);
    wr(4'd6, 4'hF, 32'h8001_0000);
    rd(4'd5, v);
    check("R5 clear", v, 0);

    // R7 synchronizer depth and write ignored
    @(negedge clk);
    pad_in = 16'hC3A5; bus_addr = 4'd4;
    #1 check("R7 before any edge", bus_rdata, 0);
    @(negedge clk); #1 check("R7 after one edge", bus_rdata, 0);
    @(negedge clk); #1 check("R7 after two edges", bus_rdata, 32'hC3A5);
    wr(4'd4, 4'hF, 32'hFFFF_FFFF);
    rd(4'd4, v);
    check("R7 write ignored", v, 32'hC3A5);

    // R8 pad drive sweep
    wr(4'd3, 4'hF, 0);
    for (int y = 0; y < 16; y++)
      for (int m = 0; m < 4; m++)
        for (int t = 0; t < 2; t++)
          for (int d = 0; d < 2; d++) begin
            wr(4'd0, 4'hF, 32'(m) << (2 * y));
            wr(4'd1, 4'hF, 32'(t) << y);
            wr(4'd5, 4'hF, 32'(d) << y);
            exp = 0;
            if (m == 1) begin
              exp[16 + y] = t ? ~d[0] : 1'b1;
              exp[y]      = t ? 1'b0 : d[0];
            end
            check("R8 pad drive", {pad_oe, pad_out}, exp);
          end

    // R9 pull sweep
    for (int y = 0; y < 16; y++)
      for (int p = 0; p < 4; p++) begin
        wr(4'd3, 4'hF, 32'(p) << (2 * y));
        exp = 0;
        exp[16 + y] = (p == 1);
        exp[y]      = (p == 2);
        check("R9 pull request", {pad_pu, pad_pd}, exp);
      end

    // R11 lock on each configuration register
    for (int k = 0; k < 6; k++) begin
      seed = nxt(seed); lk = seed;
      for (int r = 0; r < 6; r++) begin
        logic [3:0] a;
        a = (r == 4) ? 4'd7 : (r == 5) ? 4'd8 : 4'(r);
        seed = nxt(seed); a_val = seed;
        seed = nxt(seed); b_val = seed;
        pin_lock = 0;
        wr(a, 4'hF, a_val);
        pin_lock = lk[15:0];
        wr(a, 4'hF, b_val);
        rd(a, v);
        exp = (a_val & lockmask(a, lk[15:0])) | (b_val & ~lockmask(a, lk[15:0]));
        if (a == 4'd1) exp[31:16] = 0;
        check("R11 locked fields hold", v, exp);
      end
    end

    // R12 latch unaffected by lock
    pin_lock = 16'hFFFF;
    wr(4'd5, 4'hF, 32'h0000_1234);
    rd(4'd5, v);
    check("R12 latch write under lock", v, 32'h1234);
    wr(4'd6, 4'hF, 32'h1230_00C0);
    rd(4'd5, v);
    check("R12 set/clear under lock", v, 32'h00C4);
    pin_lock = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule